// File: doc/BRIEF.md
# User Scratch RAM Wipe Controller

This block erases a small user scratch RAM by writing every byte to all ones. A wipe is started by a falling edge on an external, asynchronous clear pin. It starts only while a wipe-enable configuration bit is set. The controller then walks the RAM addresses in ascending order, issuing one write per clock cycle. When the last byte is written, it raises a completion flag. If the completion interrupt is enabled, it also pulls an active-low interrupt line.

Host accesses are blocked for a fixed number of cycles, counted from the cycle the edge is detected. That window always spans the whole wipe. The RAM array itself, the timekeeping registers and any larger extended memory sit outside this block. Its write port reaches only the user scratch range. The configuration bits and the flag-clear strobe come from the surrounding register file.

Top module: `scratch_wipe`

## Requirements
- R10: After reset, `ramWe`, `doneFlag` and `hostLock` are 0, and `irqN` is 1 while `otherIrq` is 0.
- R3: A falling edge on `clrPinN` starts a wipe when `wipeEnable` is 1. The pin passes through two synchronizer stages, and the first write is issued within a few cycles of the edge.
- R1: A wipe writes each address from 0 up to DEPTH-1 exactly once, in ascending order. No address at or above DEPTH is driven.
- R2: Every byte written by a wipe is all ones (0xFF).
- R4: `doneFlag` becomes 1 on the clock edge right after the final write of a wipe.
- R5: A one-cycle `flagClr` pulse returns `doneFlag` to 0.
- R6: `irqN` is 0 exactly when (`doneFlag` and `doneIntEn`) or `otherIrq` is 1. Otherwise it is 1.
- R7: After a started wipe, `hostLock` is 1 for exactly LOCK_CYCLES consecutive cycles, beginning on the edge after detection. This window covers every write of the wipe.
- R8: With `wipeEnable` at 0, a falling edge on `clrPinN` causes no write, does not set `doneFlag` and does not raise `hostLock`.
- R9: A falling edge that arrives during an active wipe is ignored. The wipe is not restarted, no address is written twice, and the lock window is not lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrPinN | input | 1 | External clear pin, asynchronous, acts on its falling edge |
| wipeEnable | input | 1 | Configuration bit that allows the pin to start a wipe |
| doneIntEn | input | 1 | Completion interrupt enable |
| flagClr | input | 1 | Host writes zero to the completion flag (one-cycle pulse) |
| otherIrq | input | 1 | Any other interrupt source pending (active high) |
| ramWe | output | 1 | Scratch RAM write strobe |
| ramAddr | output | ADDR_W | Scratch RAM write address |
| ramWdata | output | DATA_W | Scratch RAM write data |
| hostLock | output | 1 | Host read and write accesses must be refused while 1 |
| doneFlag | output | 1 | Wipe completed flag |
| irqN | output | 1 | Active-low interrupt output |

## Verification
The wipe is tried with the completion interrupt enabled, with it disabled, and with a second pin edge injected mid-wipe. Comparing these separates a correct flag and interrupt path from one that ties the interrupt to the flag alone. It also exposes a controller that restarts or lengthens its lock on a repeated edge. An edge with the enable bit cleared shows that the gate blocks writes, the flag and the lock together. Holding the external interrupt source high after the flag is cleared shows the output merges the other sources rather than following the flag. A bench model of the RAM records every write's address, order and data, so skipped, repeated, out-of-range or wrong-valued bytes are all visible.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
  typedef struct packed {
    logic start;  // reset the address walk to zero
    logic step;   // issue one write and advance
  } wipeCmd_t;
endpackage

// File: rtl/wipe_dp.sv
module wipe_dp #(
  parameter int DEPTH  = 114,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wipe_pkg::wipeCmd_t     cmd,
  output logic                   lastAddr,
  output logic                   ramWe,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic [DATA_W-1:0]      ramWdata
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (cmd.start) addrQ <= '0;
    else if (cmd.step && addrQ != LAST) addrQ <= addrQ + 1'b1;
  end

  assign lastAddr = (addrQ == LAST);
  assign ramWe    = cmd.step;
  assign ramAddr  = addrQ;
  assign ramWdata = '1;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr < ADDR_W'(DEPTH))); // R1
endmodule

// File: rtl/wipe_ctrl.sv
module wipe_ctrl #(
  parameter int LOCK_CYCLES = 150,
  localparam int LCNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrPinN,
  input  logic               wipeEnable,
  input  logic               doneIntEn,
  input  logic               flagClr,
  input  logic               otherIrq,
  input  logic               lastAddr,
  output wipe_pkg::wipeCmd_t cmd,
  output logic               hostLock,
  output logic               doneFlag,
  output logic               irqN
);
  logic [2:0]        pinSync;
  logic              pinFall;
  logic              busy;
  logic              finish;
  logic [LCNT_W-1:0] lockCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= 3'b111;
    else       pinSync <= {pinSync[1:0], clrPinN};
  end
  assign pinFall = pinSync[2] & ~pinSync[1];

  assign cmd.start = pinFall & wipeEnable & ~busy;
  assign cmd.step  = busy;
  assign finish    = busy & lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busy <= 1'b0;
    else if (cmd.start) busy <= 1'b1;
    else if (finish)    busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lockCnt <= '0;
    else if (cmd.start)     lockCnt <= LCNT_W'(LOCK_CYCLES);
    else if (lockCnt != '0) lockCnt <= lockCnt - 1'b1;
  end
  assign hostLock = (lockCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        doneFlag <= 1'b0;
    else if (finish)  doneFlag <= 1'b1;
    else if (flagClr) doneFlag <= 1'b0;
  end

  assign irqN = ~((doneFlag & doneIntEn) | otherIrq);

  AST_LOCK_COVERS_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> hostLock); // R7
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rstN)
    (pinFall && !wipeEnable && !busy) |=> !busy); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lastAddr) |=> doneFlag); // R4
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !(busy && lastAddr)) |=> !doneFlag); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pinFall && !lastAddr) |=> busy); // R9
endmodule

// File: rtl/scratch_wipe.sv
module scratch_wipe #(
  parameter int DEPTH       = 114,
  parameter int DATA_W      = 8,
  parameter int LOCK_CYCLES = 150,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrPinN,
  input  logic              wipeEnable,
  input  logic              doneIntEn,
  input  logic              flagClr,
  input  logic              otherIrq,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              hostLock,
  output logic              doneFlag,
  output logic              irqN
);
  generate
    if (LOCK_CYCLES < DEPTH + 1) begin : g_badLock
      $error("LOCK_CYCLES must exceed DEPTH");
    end
  endgenerate

  wipe_pkg::wipeCmd_t cmd;
  logic lastAddr;

  wipe_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clrPinN(clrPinN), .wipeEnable(wipeEnable),
    .doneIntEn(doneIntEn), .flagClr(flagClr), .otherIrq(otherIrq),
    .lastAddr(lastAddr), .cmd(cmd), .hostLock(hostLock),
    .doneFlag(doneFlag), .irqN(irqN)
  );

  wipe_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lastAddr(lastAddr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );
endmodule

// File: tb/sim_scratch_wipe.sv
`timescale 1ns/1ps
module sim_scratch_wipe;
  localparam int DEPTH = 114;
  localparam int DATA_W = 8;
  localparam int LOCK_CYCLES = 150;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrPinN = 1'b1, wipeEnable = 1'b0, doneIntEn = 1'b0;
  logic flagClr = 1'b0, otherIrq = 1'b0;
  logic ramWe, hostLock, doneFlag, irqN;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  scratch_wipe #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LOCK_CYCLES(LOCK_CYCLES)) u0 (
    .clk(clk), .rstN(rstN), .clrPinN(clrPinN), .wipeEnable(wipeEnable),
    .doneIntEn(doneIntEn), .flagClr(flagClr), .otherIrq(otherIrq),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .hostLock(hostLock), .doneFlag(doneFlag), .irqN(irqN)
  );

  // Bench RAM model and write bookkeeping
  logic monClr = 1'b0;
  logic [7:0] mem [0:(1<<ADDR_W)-1];
  int writes = 0, orderErr = 0, rangeErr = 0, dataErr = 0, nextAddr = 0;
  int lockCycles = 0;

  always @(posedge clk) begin
    if (monClr) begin
      for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = 8'h00;
      writes = 0; orderErr = 0; rangeErr = 0; dataErr = 0; nextAddr = 0;
    end else if (ramWe) begin
      if (int'(ramAddr) >= DEPTH) rangeErr++;
      if (int'(ramAddr) != nextAddr) orderErr++;
      if (ramWdata != 8'hFF) dataErr++;
      mem[ramAddr] = ramWdata;
      nextAddr = int'(ramAddr) + 1;
      writes++;
    end
  end

  always @(negedge clk) begin
    if (monClr) lockCycles = 0;
    else if (hostLock) lockCycles++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic resetMon();
    @(negedge clk) monClr = 1'b1;
    @(negedge clk) monClr = 1'b0;
  endtask

  task automatic pulsePin();
    @(negedge clk) clrPinN = 1'b0;
    repeat (3) @(negedge clk);
    clrPinN = 1'b1;
  endtask

  function automatic int onesCount();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] == 8'hFF) n++;
    return n;
  endfunction

  task automatic testReset();
    @(negedge clk);
    chk(!ramWe && !doneFlag && !hostLock && irqN, "R10 reset state",
        {ramWe, doneFlag, hostLock, irqN}, 4'b0001);
  endtask

  task automatic testWipe(input bit intEn);
    int waitCyc = 0;
    resetMon();
    wipeEnable = 1'b1; doneIntEn = intEn;
    pulsePin();
    while (!doneFlag && waitCyc < 400) begin @(negedge clk); waitCyc++; end
    chk(doneFlag, "R3 wipe started and R4 flag set", doneFlag, 1);
    chk(writes == DEPTH && orderErr == 0, "R1 count and order", writes, DEPTH);
    chk(rangeErr == 0, "R1 address range", rangeErr, 0);
    chk(dataErr == 0 && onesCount() == DEPTH, "R2 all ones", onesCount(), DEPTH);
    chk(irqN == !intEn, "R6 irq follows enable", irqN, !intEn);
    repeat (LOCK_CYCLES) @(negedge clk);
    chk(lockCycles == LOCK_CYCLES && !hostLock, "R7 lock window", lockCycles, LOCK_CYCLES);
  endtask

  task automatic testFlagClear();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
    chk(!doneFlag, "R5 flag cleared", doneFlag, 0);
    chk(irqN, "R6 irq released", irqN, 1);
  endtask

  task automatic testFinishTiming();
    // flag must rise right after the last write, not later
    int lastWe = -1, flagAt = -1;
    resetMon();
    wipeEnable = 1'b1; doneIntEn = 1'b1;
    pulsePin();
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (ramWe) lastWe = c;
      if (doneFlag && flagAt < 0) flagAt = c;
    end
    chk(flagAt == lastWe + 1, "R4 flag one cycle after last write", flagAt, lastWe + 1);
    testFlagClear();
  endtask

  task automatic testDisabled();
    resetMon();
    wipeEnable = 1'b0; doneIntEn = 1'b1;
    pulsePin();
    repeat (250) @(negedge clk);
    chk(writes == 0, "R8 no writes when disabled", writes, 0);
    chk(!doneFlag && irqN, "R8 flag untouched", doneFlag, 0);
    chk(lockCycles == 0, "R8 no lock when disabled", lockCycles, 0);
  endtask

  task automatic testDoubleEdge();
    resetMon();
    wipeEnable = 1'b1; doneIntEn = 1'b1;
    pulsePin();
    repeat (40) @(negedge clk);
    pulsePin();
    repeat (LOCK_CYCLES + 60) @(negedge clk);
    chk(writes == DEPTH && orderErr == 0, "R9 no restart", writes, DEPTH);
    chk(lockCycles == LOCK_CYCLES, "R9 lock not extended", lockCycles, LOCK_CYCLES);
    testFlagClear();
  endtask

  task automatic testOtherSource();
    @(negedge clk) otherIrq = 1'b1;
    @(negedge clk);
    chk(!irqN && !doneFlag, "R6 other source drives irq", irqN, 0);
    otherIrq = 1'b0;
    @(negedge clk);
    chk(irqN, "R6 irq high with no source", irqN, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWipe(1'b1);
    testFlagClear();
    testWipe(1'b0);
    testFlagClear();
    testFinishTiming();
    testDisabled();
    testDoubleEdge();
    testOtherSource();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule